// File: doc/BRIEF.md
# Reset Supervisor Timing Sequencer

This block turns digital comparator flags and a manual-reset pin into a processor reset with clean, cycle-counted timing. A supply-below-threshold flag forces reset directly. Once the flag clears, reset is held for a selectable timeout before it releases. An active-low manual-reset pin is treated as a request only after it has stayed low for a minimum pulse width. It then asserts reset after a further short delay and holds it until the pin returns high and a full timeout has elapsed. Any new dropout or manual-reset hold restarts the timeout from zero.

Two further comparator flags, power-fail and low-line, are synchronized and passed through as active-low warning outputs. All asynchronous inputs pass through two-flop synchronizers. One free-running prescaler derived from `CLK_HZ` produces a one-microsecond tick. The qualification, delay and timeout counters all count that tick, so every delay is written in microseconds and is accurate to within one tick.

Top module: `reset_supervisor_seq`

## Requirements
- R1: While `supply_low` is high, reset is asserted no later than the third clock edge after the flag rises, and it stays asserted for as long as the flag stays high, whatever the timer holds.
- R2: After `supply_low` falls, reset releases one selected timeout later, within one microsecond tick plus the synchronizer latency. A new high level on `supply_low` before then restarts the timeout from zero.
- R3: A low pulse on `mrst_n` that lasts no longer than `QUAL_US` microseconds is ignored, and the reset output does not change.
- R4: A low level on `mrst_n` that lasts more than `QUAL_US` microseconds asserts reset `DLY_US` microseconds after qualification. The assertion lands between (QUAL_US+DLY_US) and (QUAL_US+DLY_US+1) microseconds after the falling edge. Once the request is qualified, the assertion happens even if the pin returns high during the delay, and a full timeout follows.
- R5: Reset stays asserted while `mrst_n` is held low. It releases one selected timeout after `mrst_n` returns high.
- R6: `tsel` selects the timeout: code 0 gives `TOUT_A_US`, 1 gives `TOUT_B_US`, 2 gives `TOUT_C_US` and 3 gives `TOUT_D_US` microseconds.
- R7: With `ACTIVE_HIGH` = 0, `rst_out` is low while reset is asserted. With `ACTIVE_HIGH` = 1, `rst_out` is the exact inverse of that output on every cycle.
- R8: `pf_n` equals the inverse of `pf_low` as sampled two clock edges earlier.
- R9: `ll_n` equals the inverse of `ll_low` as sampled two clock edges earlier.
- R10: While `rst_n` is low, reset is asserted, `pf_n` and `ll_n` are low and the timeout counter is cleared. After `rst_n` rises, reset releases through the same timeout sequence as a supply recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock at `CLK_HZ` |
| rst_n | input | 1 | Power-on reset of the logic, active low |
| supply_low | input | 1 | Asynchronous flag: supply below the reset threshold |
| mrst_n | input | 1 | Asynchronous manual-reset request, active low |
| tsel | input | 2 | Timeout select code |
| pf_low | input | 1 | Asynchronous flag: power-fail input below threshold |
| ll_low | input | 1 | Asynchronous flag: supply below the low-line threshold |
| rst_out | output | 1 | Processor reset, polarity set by `ACTIVE_HIGH` |
| pf_n | output | 1 | Power-fail warning, active low |
| ll_n | output | 1 | Low-line warning, active low |

## Verification
The supply recovery and the end of a manual-reset hold can fall in the same clock cycle. Both are then trying to start the timeout at once. The bench provokes this by raising `supply_low` and holding `mrst_n` low until reset is asserted, then clearing both inputs on the same clock edge. It judges the result by measuring the cycles until release: the release must land in the window for exactly one timeout, with neither an early release nor a doubled timeout. A second case stacks a supply dropout on top of a pending timeout and requires the count to restart.

// File: rtl/reset_supervisor_seq.sv
module reset_supervisor_seq #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int QUAL_US     = 25,
  parameter int DLY_US      = 12,
  parameter int TOUT_A_US   = 1400,
  parameter int TOUT_B_US   = 28000,
  parameter int TOUT_C_US   = 200000,
  parameter int TOUT_D_US   = 1600000,
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       mrst_n,
  input  logic [1:0] tsel,
  input  logic       pf_low,
  input  logic       ll_low,
  output logic       rst_out,
  output logic       pf_n,
  output logic       ll_n
);

  localparam int DIV  = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TAB  = (TOUT_A_US > TOUT_B_US) ? TOUT_A_US : TOUT_B_US;
  localparam int TCD  = (TOUT_C_US > TOUT_D_US) ? TOUT_C_US : TOUT_D_US;
  localparam int TMAX = (TAB > TCD) ? TAB : TCD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int MMAX = (QUAL_US > DLY_US) ? QUAL_US : DLY_US;
  localparam int MW   = $clog2(MMAX + 1);
  localparam logic [3:0] SYNC_INIT = 4'b1101;

  typedef enum logic [1:0] {M_IDLE, M_QUAL, M_DLY, M_HOLD} mr_state_t;

  logic [3:0]    sync1, sync2;
  logic [PW-1:0] pre;
  logic          tick;
  mr_state_t     mst;
  logic [MW-1:0] mcnt;
  logic          mr_hold, hold_cond;
  logic [TW-1:0] tcnt, limit;
  logic          rst_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= SYNC_INIT;
      sync2 <= SYNC_INIT;
    end else begin
      sync1 <= {ll_low, pf_low, ~mrst_n, supply_low};
      sync2 <= sync1;
    end

  assign tick = (pre == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mst  <= M_IDLE;
      mcnt <= '0;
    end else begin
      case (mst)
        M_IDLE:
          if (sync2[1]) begin
            mst  <= M_QUAL;
            mcnt <= '0;
          end
        M_QUAL:
          if (!sync2[1]) mst <= M_IDLE;
          else if (tick) begin
            if (mcnt == MW'(QUAL_US)) begin
              mst  <= M_DLY;
              mcnt <= '0;
            end else mcnt <= mcnt + MW'(1);
          end
        M_DLY:
          if (tick) begin
            if (mcnt >= MW'(DLY_US - 1)) begin
              mst  <= M_HOLD;
              mcnt <= '0;
            end else mcnt <= mcnt + MW'(1);
          end
        default:
          if (!sync2[1]) mst <= M_IDLE;
      endcase
    end

  assign mr_hold   = (mst == M_HOLD);
  assign hold_cond = sync2[0] | mr_hold;

  always_comb
    case (tsel)
      2'd0:    limit = TW'(TOUT_A_US);
      2'd1:    limit = TW'(TOUT_B_US);
      2'd2:    limit = TW'(TOUT_C_US);
      default: limit = TW'(TOUT_D_US);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_act <= 1'b1;
      tcnt    <= '0;
    end else if (hold_cond) begin
      rst_act <= 1'b1;
      tcnt    <= '0;
    end else if (rst_act && tick) begin
      if (tcnt >= limit - TW'(1)) begin
        rst_act <= 1'b0;
        tcnt    <= '0;
      end else tcnt <= tcnt + TW'(1);
    end

  assign rst_out = ACTIVE_HIGH ? rst_act : ~rst_act;
  assign pf_n    = ~sync2[2];
  assign ll_n    = ~sync2[3];

endmodule

// File: rtl/reset_supervisor_seq_chk.sv
module reset_supervisor_seq_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pf_low,
  input logic          ll_low,
  input logic          pf_n,
  input logic          ll_n,
  input logic          sup_s,
  input logic          mr_hold,
  input logic          in_delay,
  input logic          rst_act,
  input logic [TW-1:0] tcnt
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              age <= '0;
    else if (age != 2'd3)    age <= age + 2'd1;

  p_sup_forces_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sup_s |=> rst_act);

  p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> (!$past(sup_s) && !$past(mr_hold)));

  p_idle_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_act |-> (tcnt == '0));

  p_mr_via_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_hold) |-> $past(in_delay));

  p_mr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mr_hold |=> rst_act);

  p_pf_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pf_n == !$past(pf_low, 2)));

  p_ll_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (ll_n == !$past(ll_low, 2)));

endmodule

bind reset_supervisor_seq reset_supervisor_seq_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pf_low   (pf_low),
  .ll_low   (ll_low),
  .pf_n     (pf_n),
  .ll_n     (ll_n),
  .sup_s    (sync2[0]),
  .mr_hold  (mr_hold),
  .in_delay (mst == M_DLY),
  .rst_act  (rst_act),
  .tcnt     (tcnt)
);

// File: tb/reset_supervisor_seq_bench.sv
module reset_supervisor_seq_bench;
  localparam int CPU = 50;
  localparam int Q = 25, D = 12;
  localparam int TA = 20, TB = 30, TC = 40, TD = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup = 1'b0, mrn = 1'b1, pf = 1'b0, ll = 1'b0;
  logic [1:0] sel = 2'd0;
  logic rlo, rhi, pfn, lln, pfn_h, lln_h;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_supervisor_seq #(.CLK_HZ(50_000_000), .QUAL_US(Q), .DLY_US(D),
    .TOUT_A_US(TA), .TOUT_B_US(TB), .TOUT_C_US(TC), .TOUT_D_US(TD),
    .ACTIVE_HIGH(1'b0)) u_reset_supervisor_seq (
    .clk(clk), .rst_n(rst_n), .supply_low(sup), .mrst_n(mrn), .tsel(sel),
    .pf_low(pf), .ll_low(ll), .rst_out(rlo), .pf_n(pfn), .ll_n(lln));

  reset_supervisor_seq #(.CLK_HZ(50_000_000), .QUAL_US(Q), .DLY_US(D),
    .TOUT_A_US(TA), .TOUT_B_US(TB), .TOUT_C_US(TC), .TOUT_D_US(TD),
    .ACTIVE_HIGH(1'b1)) u_reset_supervisor_seq_hi (
    .clk(clk), .rst_n(rst_n), .supply_low(sup), .mrst_n(mrn), .tsel(sel),
    .pf_low(pf), .ll_low(ll), .rst_out(rhi), .pf_n(pfn_h), .ll_n(lln_h));

  function automatic int tout(input logic [1:0] s);
    case (s)
      2'd0: return TA;
      2'd1: return TB;
      2'd2: return TC;
      default: return TD;
    endcase
  endfunction
  function automatic int rel_min(input logic [1:0] s); return (tout(s) - 1) * CPU; endfunction
  function automatic int rel_max(input logic [1:0] s); return tout(s) * CPU + 8; endfunction
  localparam int MR_MIN = (Q + D) * CPU;
  localparam int MR_MAX = (Q + D + 1) * CPU + 8;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int n, input int lo, input int hi);
    checks++;
    if (n < lo || n > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_lo(input logic want, output int n);
    n = 0;
    while (rlo !== want && n < 10000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sup_pulse(input int len);
    sup = 1'b1;
    cyc(len);
    sup = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, k;
    bit ok;
    void'($urandom(32'h5eed));
    cyc(5);
    chk(rlo == 1'b0, "R10 reset asserted in power-on", rlo, 0);
    chk(rhi == 1'b1, "R7 active-high during power-on", rhi, 1);
    chk(pfn == 1'b0 && lln == 1'b0, "R10 warnings low in power-on", {pfn, lln}, 0);

    rst_n = 1'b1;
    wait_lo(1'b1, n);
    chk_win("R10 power-on release", n, rel_min(0), rel_max(0));
    chk(pfn == 1'b1, "R8 pf_n high", pfn, 1);
    chk(lln == 1'b1, "R9 ll_n high", lln, 1);
    chk(rhi == !rlo, "R7 inverse output", rhi, !rlo);

    sel = 2'd1;
    sup = 1'b1;
    cyc(10);
    chk(rlo == 1'b0, "R1 supply low asserts", rlo, 0);
    sup = 1'b0;
    cyc(TB * CPU / 2);
    chk(rlo == 1'b0, "R2 still held mid-timeout", rlo, 0);
    sup_pulse(6);
    wait_lo(1'b1, n);
    chk_win("R2 restart after dropout", n, rel_min(1), rel_max(1));

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      sup_pulse(10);
      wait_lo(1'b1, n);
      chk_win($sformatf("R6 timeout code %0d", s), n, rel_min(2'(s)), rel_max(2'(s)));
    end

    sel = 2'd0;
    mrn = 1'b0;
    cyc(20 * CPU);
    mrn = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rlo !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R3 short manual pulse ignored", ok, 1);

    mrn = 1'b0;
    wait_lo(1'b0, n);
    chk_win("R4 manual assert latency", n, MR_MIN, MR_MAX);
    ok = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (rlo !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R5 held while manual low", ok, 1);
    chk(rhi == 1'b1, "R7 inverse during manual hold", rhi, 1);
    mrn = 1'b1;
    wait_lo(1'b1, n);
    chk_win("R5 release after manual high", n, rel_min(0), rel_max(0));

    mrn = 1'b0;
    cyc(30 * CPU);
    mrn = 1'b1;
    wait_lo(1'b0, n);
    chk_win("R4 qualified pulse completes", n + 30 * CPU, MR_MIN, MR_MAX);
    wait_lo(1'b1, n);
    chk_win("R4 timeout after short qualified", n, rel_min(0), rel_max(0));

    sel = 2'd2;
    sup = 1'b1;
    mrn = 1'b0;
    cyc(MR_MAX + 200);
    chk(rlo == 1'b0, "R1 both sources asserted", rlo, 0);
    sup = 1'b0;
    mrn = 1'b1;
    wait_lo(1'b1, n);
    chk_win("R2 same-cycle supply and manual clear", n, rel_min(2), rel_max(2));

    for (int it = 0; it < 8; it++) begin
      sel = 2'($urandom % 4);
      pf = 1'($urandom);
      ll = 1'($urandom);
      cyc(3);
      chk(pfn == !pf, "R8 random pf", pfn, !pf);
      chk(lln == !ll, "R9 random ll", lln, !ll);
      k = 4 + ($urandom % 100);
      sup = 1'b1;
      cyc(k);
      chk(rlo == 1'b0, "R1 random dropout", rlo, 0);
      sup = 1'b0;
      wait_lo(1'b1, n);
      chk_win("R2 random release", n, rel_min(sel), rel_max(sel));
      chk(rhi == !rlo, "R7 random inverse", rhi, !rlo);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule